// File: doc/BRIEF.md
# SPI Burst Master

This block is a memory-mapped SPI master that moves bursts of bytes between two byte FIFOs and a serial bus. Software fills the transmit FIFO through a byte-wide data port, writes the byte count of the burst, picks the clock polarity, clock phase and chip-select line, and then writes the exchange bit. The engine shifts each byte out MSB first and captures the incoming byte at the same time. It pushes every received byte into the receive FIFO and clears the exchange bit on its own when the burst is done. Software polls that bit and then drains the receive FIFO.

Bit timing comes from outside. An external divider supplies `bit_tick`, and each tick ends one half period of SCK. The divider setting is kept in a plain register and driven out on `clk_cfg` for that divider. Chip select can be driven in two ways: by hand, through a level bit that holds between bursts, or automatically for the length of a burst. Its polarity can be set.

Both FIFOs use valid/ready internally, and the rules at the edges are fixed. A write to the transmit data port while that FIFO is full is dropped. If the transmit FIFO runs empty during a burst, the engine sends 0x00. When the receive FIFO is full, a received byte is either dropped or, if the stall bit is set, held by the engine until software reads a byte out.

Top module: `spi_burst_master`

## Requirements
- R1: After reset every register reads 0, both FIFOs are empty, `spi_sck` is 0 and all `spi_cs` lines are 0.
- R2: Writing 1 to transfer control bit 31 starts a burst only if global control bit 0 (enable) and bit 1 (master) are both 1. Bit 31 then reads 1 and drops to 0 by itself after the burst. If either enable bit is 0, the write is ignored, bit 31 stays 0 and SCK does not move.
- R3: A burst moves exactly the number of bytes in the 24-bit burst count (offset 0x30). A count of 0 completes at once with no SCK edge.
- R4: The idle SCK level equals CPOL (transfer control bit 1). Each byte takes 16 SCK transitions. MOSI carries the byte MSB first and is stable at the sampling edge: the leading edge when CPHA (bit 0) is 0, the trailing edge when CPHA is 1.
- R5: The exchange is full duplex: the byte pushed into the receive FIFO is the MISO value taken at the same sampling edges, MSB first.
- R6: When the transmit FIFO is empty during a burst, the engine shifts out 0x00 for that byte.
- R7: With global control bit 7 at 0, a byte received while the receive FIFO is full is dropped. With bit 7 at 1, the engine holds that byte, keeps bit 31 at 1, and continues once a byte has been read from the receive FIFO at offset 0x300.
- R8: When transfer control bit 6 (manual) is 1, the line chosen by bits [5:4] is asserted while bit 7 (level) is 0, and this holds between bursts. The other lines stay deasserted. Bit 2 set means asserted is low; bit 2 clear means asserted is high.
- R9: When manual mode is off, the chosen line is asserted only while bit 31 reads 1.
- R10: Writing 1 to FIFO control (offset 0x18) bit 15 empties the receive FIFO and writing 1 to bit 31 empties the transmit FIFO. Both bits read back 0.
- R11: Writing 1 to global control bit 31 aborts any burst, clears transfer control bit 31, empties both FIFOs, returns SCK to idle and reads back 0. The other global bits keep the written values.
- R12: FIFO status (offset 0x1C) reports the receive FIFO level in bits [7:0] and the transmit FIFO level in bits [23:16].
- R13: Burst count, transmit count (0x34) and burst control (0x38) keep 24 bits and read upper bits as 0. Clock control (0x24) keeps 32 bits and drives `clk_cfg`.
- R14: A write to the transmit data port (offset 0x200, bits [7:0]) while the transmit FIFO is full is dropped, and the level stays at the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 1 | Register access this cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 10 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read |
| bit_tick | input | 1 | One pulse per SCK half period |
| clk_cfg | output | 32 | Clock control value for the external divider |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | NUM_CS | Chip-select lines, polarity set by software |

## Verification
The hardest case to reach is the receive-full stall. It needs the receive FIFO to fill in the middle of a single burst while the transmit FIFO has already run dry. The bench builds the design with an 8-byte FIFO and queues 7 bytes against a burst count of 10. It loops MOSI back to MISO through an inverter, so the zero fill shows up as 0xFF. With this setup, a dropped byte and a held byte give different read sequences. The bench runs the burst once with the stall bit clear and once with it set. In the second run it reads the FIFO while the exchange bit is still 1.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  localparam int REG_AW = 10;

  localparam logic [REG_AW-1:0] OFF_GCTL  = 10'h004;
  localparam logic [REG_AW-1:0] OFF_XCTL  = 10'h008;
  localparam logic [REG_AW-1:0] OFF_FCTL  = 10'h018;
  localparam logic [REG_AW-1:0] OFF_FSTAT = 10'h01C;
  localparam logic [REG_AW-1:0] OFF_CLK   = 10'h024;
  localparam logic [REG_AW-1:0] OFF_BCNT  = 10'h030;
  localparam logic [REG_AW-1:0] OFF_TCNT  = 10'h034;
  localparam logic [REG_AW-1:0] OFF_BCTL  = 10'h038;
  localparam logic [REG_AW-1:0] OFF_TXD   = 10'h200;
  localparam logic [REG_AW-1:0] OFF_RXD   = 10'h300;

  localparam int G_EN    = 0;
  localparam int G_MST   = 1;
  localparam int G_STALL = 7;
  localparam int G_SRST  = 31;

  localparam int X_CPHA  = 0;
  localparam int X_CPOL  = 1;
  localparam int X_LOW   = 2;
  localparam int X_SEL   = 4;
  localparam int X_MAN   = 6;
  localparam int X_LVL   = 7;
  localparam int X_GO    = 31;

  localparam int F_RXCLR = 15;
  localparam int F_TXCLR = 31;

  typedef enum logic [2:0] {
    EN_IDLE, EN_LOAD, EN_SHIFT, EN_PUSH, EN_FINISH
  } eng_state_t;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  output logic [LW-1:0] level
);
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign in_ready  = (level != FULL_LVL);
  assign out_valid = (level != '0);
  assign out_data  = mem[rd_ptr];
  assign do_push   = in_valid && in_ready;
  assign do_pop    = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_burst_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             start,
  input  logic [CNT_W-1:0] byte_count,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             stall_on_full,
  input  logic             tick,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [7:0]       tx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [7:0]       rx_data,
  input  logic             miso,
  output logic             sck,
  output logic             mosi,
  output logic             busy,
  output logic             done
);
  eng_state_t       state;
  logic [CNT_W-1:0] remain;
  logic [3:0]       edge_q;
  logic             phase_q;
  logic [7:0]       tx_sr, rx_sr;
  logic             mosi_q;
  logic [7:0]       load_byte;

  assign sck       = phase_q ^ cpol;
  assign mosi      = mosi_q;
  assign busy      = (state != EN_IDLE);
  assign done      = (state == EN_FINISH);
  assign tx_ready  = (state == EN_LOAD);
  assign rx_valid  = (state == EN_PUSH);
  assign rx_data   = rx_sr;
  assign load_byte = tx_valid ? tx_data : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= EN_IDLE;
      remain  <= '0;
      edge_q  <= '0;
      phase_q <= 1'b0;
      tx_sr   <= '0;
      rx_sr   <= '0;
      mosi_q  <= 1'b0;
    end else if (abort) begin
      state   <= EN_IDLE;
      remain  <= '0;
      edge_q  <= '0;
      phase_q <= 1'b0;
    end else begin
      case (state)
        EN_IDLE: begin
          if (start) begin
            remain <= byte_count;
            state  <= (byte_count == '0) ? EN_FINISH : EN_LOAD;
          end
        end
        EN_LOAD: begin
          if (!cpha) begin
            mosi_q <= load_byte[7];
            tx_sr  <= {load_byte[6:0], 1'b0};
          end else begin
            tx_sr  <= load_byte;
          end
          edge_q <= '0;
          state  <= EN_SHIFT;
        end
        EN_SHIFT: begin
          if (tick) begin
            phase_q <= ~phase_q;
            edge_q  <= edge_q + 1'b1;
            if (!edge_q[0]) begin
              if (!cpha) rx_sr <= {rx_sr[6:0], miso};
              else begin
                mosi_q <= tx_sr[7];
                tx_sr  <= {tx_sr[6:0], 1'b0};
              end
            end else begin
              if (cpha) rx_sr <= {rx_sr[6:0], miso};
              else if (edge_q != 4'd15) begin
                mosi_q <= tx_sr[7];
                tx_sr  <= {tx_sr[6:0], 1'b0};
              end
            end
            if (edge_q == 4'd15) begin
              remain <= remain - 1'b1;
              state  <= EN_PUSH;
            end
          end
        end
        EN_PUSH: begin
          if (rx_ready || !stall_on_full)
            state <= (remain == '0) ? EN_FINISH : EN_LOAD;
        end
        EN_FINISH: state <= EN_IDLE;
        default:   state <= EN_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import spi_burst_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int CNT_W  = 24,
  parameter int NUM_CS = 4,
  localparam int LVL_W = $clog2(DEPTH) + 1,
  localparam int SEL_W = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              bit_tick,
  output logic [31:0]       clk_cfg,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs
);
  logic             en_q, mst_q, stall_q, srst_q;
  logic             cpha, cpol, cs_pol_low, cs_man, cs_lvl, xch_q;
  logic [SEL_W-1:0] cs_sel;
  logic             rxclr_q, txclr_q;
  logic [31:0]      clk_q;
  logic [CNT_W-1:0] bcnt_q, tcnt_q, bctl_q;

  logic wr_en, rd_en, start;
  logic [31:0] xctl_rd, rd_mux;

  logic             tx_in_ready, tx_out_valid, tx_out_ready;
  logic [7:0]       tx_head;
  logic [LVL_W-1:0] tx_lvl;
  logic             rx_in_valid, rx_in_ready, rx_out_valid, rx_pop;
  logic [7:0]       rx_in_data, rx_head;
  logic [LVL_W-1:0] rx_lvl;
  logic             eng_busy, eng_done, cs_on;

  assign wr_en   = reg_sel && reg_wr;
  assign rd_en   = reg_sel && !reg_wr;
  assign start   = wr_en && (reg_addr == OFF_XCTL) && reg_wdata[X_GO]
                   && en_q && mst_q && !xch_q && !srst_q;
  assign rx_pop  = rd_en && (reg_addr == OFF_RXD);
  assign clk_cfg = clk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; mst_q <= 1'b0; stall_q <= 1'b0; srst_q <= 1'b0;
      cpha <= 1'b0; cpol <= 1'b0; cs_pol_low <= 1'b0; cs_man <= 1'b0;
      cs_lvl <= 1'b0; cs_sel <= '0; xch_q <= 1'b0;
      rxclr_q <= 1'b0; txclr_q <= 1'b0;
      clk_q <= '0; bcnt_q <= '0; tcnt_q <= '0; bctl_q <= '0;
    end else begin
      srst_q  <= wr_en && (reg_addr == OFF_GCTL) && reg_wdata[G_SRST];
      rxclr_q <= wr_en && (reg_addr == OFF_FCTL) && reg_wdata[F_RXCLR];
      txclr_q <= wr_en && (reg_addr == OFF_FCTL) && reg_wdata[F_TXCLR];
      if (wr_en) begin
        case (reg_addr)
          OFF_GCTL: begin
            en_q    <= reg_wdata[G_EN];
            mst_q   <= reg_wdata[G_MST];
            stall_q <= reg_wdata[G_STALL];
          end
          OFF_XCTL: begin
            cpha       <= reg_wdata[X_CPHA];
            cpol       <= reg_wdata[X_CPOL];
            cs_pol_low <= reg_wdata[X_LOW];
            cs_sel     <= reg_wdata[X_SEL +: SEL_W];
            cs_man     <= reg_wdata[X_MAN];
            cs_lvl     <= reg_wdata[X_LVL];
          end
          OFF_CLK:  clk_q  <= reg_wdata;
          OFF_BCNT: bcnt_q <= reg_wdata[CNT_W-1:0];
          OFF_TCNT: tcnt_q <= reg_wdata[CNT_W-1:0];
          OFF_BCTL: bctl_q <= reg_wdata[CNT_W-1:0];
          default: ;
        endcase
      end
      if (srst_q || eng_done) xch_q <= 1'b0;
      else if (start)         xch_q <= 1'b1;
    end
  end

  always_comb begin
    xctl_rd                  = '0;
    xctl_rd[X_CPHA]          = cpha;
    xctl_rd[X_CPOL]          = cpol;
    xctl_rd[X_LOW]           = cs_pol_low;
    xctl_rd[X_SEL +: SEL_W]  = cs_sel;
    xctl_rd[X_MAN]           = cs_man;
    xctl_rd[X_LVL]           = cs_lvl;
    xctl_rd[X_GO]            = xch_q;
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      OFF_GCTL: begin
        rd_mux[G_EN]    = en_q;
        rd_mux[G_MST]   = mst_q;
        rd_mux[G_STALL] = stall_q;
        rd_mux[G_SRST]  = srst_q;
      end
      OFF_XCTL: rd_mux = xctl_rd;
      OFF_FCTL: begin
        rd_mux[F_RXCLR] = rxclr_q;
        rd_mux[F_TXCLR] = txclr_q;
      end
      OFF_FSTAT: begin
        rd_mux[7:0]   = 8'(rx_lvl);
        rd_mux[23:16] = 8'(tx_lvl);
      end
      OFF_CLK:  rd_mux = clk_q;
      OFF_BCNT: rd_mux = 32'(bcnt_q);
      OFF_TCNT: rd_mux = 32'(tcnt_q);
      OFF_BCTL: rd_mux = 32'(bctl_q);
      OFF_RXD:  rd_mux = rx_out_valid ? {24'h0, rx_head} : 32'h0;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     reg_rdata <= '0;
    else if (rd_en) reg_rdata <= rd_mux;
  end

  spi_byte_fifo #(.DEPTH(DEPTH), .W(8)) u_txf (
    .clk(clk), .rst_n(rst_n), .clr(txclr_q || srst_q),
    .in_valid(wr_en && (reg_addr == OFF_TXD)), .in_ready(tx_in_ready),
    .in_data(reg_wdata[7:0]),
    .out_valid(tx_out_valid), .out_ready(tx_out_ready), .out_data(tx_head),
    .level(tx_lvl)
  );

  spi_byte_fifo #(.DEPTH(DEPTH), .W(8)) u_rxf (
    .clk(clk), .rst_n(rst_n), .clr(rxclr_q || srst_q),
    .in_valid(rx_in_valid), .in_ready(rx_in_ready), .in_data(rx_in_data),
    .out_valid(rx_out_valid), .out_ready(rx_pop), .out_data(rx_head),
    .level(rx_lvl)
  );

  spi_shift_engine #(.CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .abort(srst_q), .start(start),
    .byte_count(bcnt_q), .cpol(cpol), .cpha(cpha), .stall_on_full(stall_q),
    .tick(bit_tick),
    .tx_valid(tx_out_valid), .tx_ready(tx_out_ready), .tx_data(tx_head),
    .rx_valid(rx_in_valid), .rx_ready(rx_in_ready), .rx_data(rx_in_data),
    .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi),
    .busy(eng_busy), .done(eng_done)
  );

  assign cs_on = cs_man ? !cs_lvl : xch_q;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    logic line_on;
    assign line_on   = cs_on && (cs_sel == SEL_W'(i));
    assign spi_cs[i] = cs_pol_low ? !line_on : line_on;
  end
endmodule

// File: rtl/spi_burst_master_chk.sv
module spi_burst_master_chk #(
  parameter int DEPTH  = 64,
  parameter int LVL_W  = 7,
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              eng_busy,
  input logic              eng_done,
  input logic              srst_q,
  input logic              xch_q,
  input logic              cpol,
  input logic              spi_sck,
  input logic              cs_pol_low,
  input logic [NUM_CS-1:0] spi_cs,
  input logic [LVL_W-1:0]  rx_lvl
);
  logic [NUM_CS-1:0] cs_active;
  assign cs_active = cs_pol_low ? ~spi_cs : spi_cs;

  assert_idle_sck_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_busy |-> (spi_sck == cpol));

  assert_single_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cs_active) <= 1);

  assert_rx_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rx_lvl) <= DEPTH);

  assert_go_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xch_q) |-> $past(eng_done || srst_q));

  assert_busy_under_go_R2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |-> xch_q);

  assert_abort_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> !eng_busy && !xch_q);
endmodule

bind spi_burst_master spi_burst_master_chk #(
  .DEPTH(DEPTH), .LVL_W(LVL_W), .NUM_CS(NUM_CS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .eng_busy(eng_busy), .eng_done(eng_done),
  .srst_q(srst_q), .xch_q(xch_q), .cpol(cpol), .spi_sck(spi_sck),
  .cs_pol_low(cs_pol_low), .spi_cs(spi_cs), .rx_lvl(rx_lvl)
);

// File: tb/spi_burst_master_bench.sv
module spi_burst_master_bench;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0, reg_wr = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, clk_cfg;
  logic        bit_tick = 1'b0;
  logic        spi_sck, spi_mosi, spi_miso;
  logic [3:0]  spi_cs;
  logic        inv = 1'b0;

  int n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;
  always @(posedge clk) bit_tick <= rst_n ? ~bit_tick : 1'b0;
  assign spi_miso = inv ? ~spi_mosi : spi_mosi;

  spi_burst_master #(.DEPTH(DEPTH)) u_spi_burst_master (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bit_tick(bit_tick), .clk_cfg(clk_cfg), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs(spi_cs)
  );

  // MOSI monitor: captures at the sampling edge for the current mode
  logic       cur_cpol = 1'b0, cur_cpha = 1'b0, mon_clr = 1'b0;
  logic       sck_prev = 1'b0;
  logic [7:0] mon_sr = '0;
  logic [7:0] mon_bytes [16];
  int         mon_bits = 0, mon_n = 0, mon_tog = 0;

  always @(posedge clk) begin
    if (mon_clr) begin
      mon_bits = 0; mon_n = 0; mon_tog = 0;
    end else if (spi_sck !== sck_prev) begin
      mon_tog++;
      if ((sck_prev == cur_cpol) ^ cur_cpha) begin
        mon_sr = {mon_sr[6:0], spi_mosi};
        mon_bits++;
        if (mon_bits == 8) begin
          if (mon_n < 16) mon_bytes[mon_n] = mon_sr;
          mon_n++;
          mon_bits = 0;
        end
      end
    end
    sck_prev = spi_sck;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
    @(posedge clk); #1 d = reg_rdata;
    @(negedge clk);
    reg_sel = 1'b0;
  endtask

  task automatic monitor_clear();
    @(negedge clk); mon_clr = 1'b1;
    @(negedge clk); mon_clr = 1'b0;
  endtask

  task automatic wait_idle(output bit ok);
    logic [31:0] v;
    ok = 1'b0;
    for (int k = 0; k < 3000; k++) begin
      rd(10'h008, v);
      if (!v[31]) begin ok = 1'b1; break; end
    end
  endtask

  function automatic logic [31:0] xctl(input bit cpha, input bit cpol, input bit low,
                                       input int sel, input bit man, input bit lvl, input bit go);
    logic [31:0] v = '0;
    v[0] = cpha; v[1] = cpol; v[2] = low; v[5:4] = sel[1:0];
    v[6] = man; v[7] = lvl; v[31] = go;
    return v;
  endfunction

  function automatic logic [7:0] pat(input int m, input int i);
    return 8'(8'hA5 ^ (i * 37) ^ (m * 16) ^ i);
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    logic [7:0]  tx [8];
    logic [7:0]  e;
    bit          ok;

    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R1: reset state
    rd(10'h004, v); chk("R1 gctl", v, 32'h0);
    rd(10'h008, v); chk("R1 xctl", v, 32'h0);
    rd(10'h01C, v); chk("R1 fstat", v, 32'h0);
    rd(10'h030, v); chk("R1 bcnt", v, 32'h0);
    chk("R1 sck", {31'h0, spi_sck}, 32'h0);
    chk("R1 cs", {28'h0, spi_cs}, 32'h0);

    // R2: go ignored when not enabled
    monitor_clear();
    wr(10'h030, 32'd2);
    wr(10'h008, xctl(0, 0, 1, 0, 1, 1, 1));
    repeat (40) @(posedge clk);
    rd(10'h008, v); chk("R2 go ignored while disabled", {31'h0, v[31]}, 32'h0);
    chk("R2 no sck while disabled", mon_tog, 0);

    wr(10'h004, 32'h3);

    // R13: counters and clock control
    wr(10'h030, 32'hFFFF_FFFF); rd(10'h030, v); chk("R13 bcnt 24b", v, 32'h00FF_FFFF);
    wr(10'h034, 32'hABCD_1234); rd(10'h034, v); chk("R13 tcnt 24b", v, 32'h00CD_1234);
    wr(10'h038, 32'h8000_0011); rd(10'h038, v); chk("R13 bctl 24b", v, 32'h0000_0011);
    wr(10'h024, 32'h1234_5007); chk("R13 clk_cfg", clk_cfg, 32'h1234_5007);

    // R3: zero-length burst
    wr(10'h030, 32'd0);
    monitor_clear();
    wr(10'h008, xctl(0, 0, 1, 0, 1, 1, 1));
    repeat (3) @(posedge clk);
    rd(10'h008, v); chk("R3 zero count done", {31'h0, v[31]}, 32'h0);
    chk("R3 zero count no sck", mon_tog, 0);

    // R4 R5 R8 R12: sweep over modes and loopback polarity
    for (int m = 0; m < 4; m++) begin
      for (int iv = 0; iv < 2; iv++) begin
        int n = m + 3;
        inv = iv[0];
        cur_cpha = m[0]; cur_cpol = m[1];
        wr(10'h008, xctl(m[0], m[1], 1, m, 1, 0, 0));
        wr(10'h018, 32'h8000_8000);
        for (int i = 0; i < n; i++) begin
          tx[i] = pat(m * 2 + iv, i);
          wr(10'h200, {24'h0, tx[i]});
        end
        rd(10'h01C, v); chk("R12 tx level", v, 32'(n) << 16);
        wr(10'h030, 32'(n));
        monitor_clear();
        wr(10'h008, xctl(m[0], m[1], 1, m, 1, 0, 1));
        rd(10'h008, v); chk("R2 go reads 1", {31'h0, v[31]}, 32'h1);
        wait_idle(ok); chk("R2 go self clears", {31'h0, ok}, 32'h1);
        chk("R4 sck transitions", mon_tog, 16 * n);
        chk("R3 byte count", mon_n, n);
        for (int i = 0; i < n; i++)
          chk("R4 mosi msb first", {24'h0, mon_bytes[i]}, {24'h0, tx[i]});
        chk("R4 idle level", {31'h0, spi_sck}, {31'h0, cur_cpol});
        chk("R8 manual cs held", {28'h0, spi_cs}, {28'h0, ~(4'b0001 << m)});
        rd(10'h01C, v); chk("R12 rx level", v, 32'(n));
        for (int i = 0; i < n; i++) begin
          e = iv[0] ? ~tx[i] : tx[i];
          rd(10'h300, v); chk("R5 rx byte", v, {24'h0, e});
        end
      end
    end
    inv = 1'b0;

    // R8: level 1 deasserts; active-high polarity
    wr(10'h008, xctl(0, 0, 1, 3, 1, 1, 0));
    chk("R8 level high deasserts", {28'h0, spi_cs}, 32'hF);
    wr(10'h008, xctl(0, 0, 0, 1, 1, 0, 0));
    chk("R8 active high select", {28'h0, spi_cs}, 32'h2);
    cur_cpol = 1'b0; cur_cpha = 1'b0;

    // R9: automatic chip select
    wr(10'h008, xctl(0, 0, 1, 2, 0, 0, 0));
    chk("R9 auto idle", {28'h0, spi_cs}, 32'hF);
    wr(10'h018, 32'h8000_8000);
    wr(10'h030, 32'd2);
    wr(10'h008, xctl(0, 0, 1, 2, 0, 0, 1));
    repeat (10) @(posedge clk); #1;
    chk("R9 auto asserted", {28'h0, spi_cs}, 32'hB);
    wait_idle(ok);
    chk("R9 auto released", {28'h0, spi_cs}, 32'hF);

    // R6: empty TX sends zeros
    wr(10'h018, 32'h8000_8000);
    wr(10'h200, 32'h5A); wr(10'h200, 32'hC3);
    wr(10'h030, 32'd4);
    wr(10'h008, xctl(0, 0, 1, 0, 1, 0, 1));
    wait_idle(ok);
    rd(10'h300, v); chk("R6 byte0", v, 32'h5A);
    rd(10'h300, v); chk("R6 byte1", v, 32'hC3);
    rd(10'h300, v); chk("R6 zero fill", v, 32'h00);
    rd(10'h300, v); chk("R6 zero fill", v, 32'h00);

    // R14 R10: TX overflow and FIFO clears
    wr(10'h018, 32'h8000_8000);
    for (int i = 0; i < DEPTH + 2; i++) wr(10'h200, 32'(i));
    rd(10'h01C, v); chk("R14 tx stays full", v, 32'(DEPTH) << 16);
    wr(10'h018, 32'h8000_0000);
    rd(10'h01C, v); chk("R10 tx cleared", v, 32'h0);
    rd(10'h018, v); chk("R10 clear bits read 0", v, 32'h0);
    wr(10'h200, 32'h11);
    wr(10'h030, 32'd1);
    wr(10'h008, xctl(0, 0, 1, 0, 1, 0, 1));
    wait_idle(ok);
    wr(10'h018, 32'h0000_8000);
    rd(10'h01C, v); chk("R10 rx cleared", v, 32'h0);

    // R7: RX full without stall drops
    inv = 1'b1;
    wr(10'h018, 32'h8000_8000);
    for (int i = 0; i < 7; i++) begin tx[i] = pat(9, i); wr(10'h200, {24'h0, tx[i]}); end
    wr(10'h030, 32'd10);
    wr(10'h008, xctl(0, 0, 1, 0, 1, 0, 1));
    wait_idle(ok); chk("R7 no stall completes", {31'h0, ok}, 32'h1);
    rd(10'h01C, v); chk("R7 rx full", v, 32'(DEPTH));
    for (int i = 0; i < 8; i++) begin
      e = (i < 7) ? ~tx[i] : 8'hFF;
      rd(10'h300, v); chk("R7 kept bytes", v, {24'h0, e});
    end
    rd(10'h01C, v); chk("R7 extra dropped", v, 32'h0);

    // R7: RX full with stall holds
    wr(10'h004, 32'h83);
    for (int i = 0; i < 7; i++) wr(10'h200, {24'h0, tx[i]});
    wr(10'h008, xctl(0, 0, 1, 0, 1, 0, 1));
    repeat (600) @(posedge clk);
    rd(10'h008, v); chk("R7 stalled go stays 1", {31'h0, v[31]}, 32'h1);
    rd(10'h01C, v); chk("R7 stalled rx full", v, 32'(DEPTH));
    for (int i = 0; i < 8; i++) begin
      e = (i < 7) ? ~tx[i] : 8'hFF;
      rd(10'h300, v); chk("R7 stall order", v, {24'h0, e});
    end
    wait_idle(ok); chk("R7 stall resumes", {31'h0, ok}, 32'h1);
    rd(10'h300, v); chk("R7 held byte", v, 32'hFF);
    rd(10'h300, v); chk("R7 held byte", v, 32'hFF);
    inv = 1'b0;

    // R11: soft reset aborts a burst
    wr(10'h004, 32'h3);
    wr(10'h008, xctl(0, 1, 1, 0, 1, 0, 0));
    for (int i = 0; i < 5; i++) wr(10'h200, 32'(i + 1));
    wr(10'h030, 32'd5);
    wr(10'h008, xctl(0, 1, 1, 0, 1, 0, 1));
    repeat (45) @(posedge clk);
    wr(10'h004, 32'h8000_0003);
    rd(10'h008, v); chk("R11 go cleared", {31'h0, v[31]}, 32'h0);
    rd(10'h01C, v); chk("R11 fifos empty", v, 32'h0);
    rd(10'h004, v); chk("R11 gctl kept", v, 32'h3);
    chk("R11 sck idle", {31'h0, spi_sck}, 32'h1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule